// File: doc/BRIEF.md
# Masked PC Breakpoint Comparator

This block is a debug trigger source that compares the processor's program counter against four programmable breakpoint addresses. Software loads the breakpoint registers, a mask register and a control word through a simple synchronous register port. The block then inspects every PC value offered with the PC-valid strobe. When a qualifying PC arrives, the block raises a one-cycle trigger pulse that the rest of the debug logic can consume.

Breakpoint 0 is compared through the mask, so a single register can describe an aligned region of addresses. Breakpoints 1 to 3 describe single addresses that must match exactly, and each is taken into account only when its own valid flag is set. The region is the union of all active matches. An enable bit gates the trigger. An invert bit makes the trigger fire for PCs that fall outside the region instead of inside it.

Top module: `pc_bkpt_trigger`

## Requirements
- R1: After synchronous reset every register (breakpoints 0 to 3, mask, control) reads back as zero and `pc_trig` is low.
- R2: A write with `reg_we` high at a clock edge updates the register selected by `reg_addr`. The addresses are 0 to 3 for breakpoints 0 to 3, 4 for the mask and 5 for control. In the control register, bit 0 is the enable and bit 1 is the invert. `reg_rdata` shows the register selected by `reg_addr` one clock later. Breakpoints 1 to 3 and the mask read back every bit as written. The upper control bits and unmapped addresses read as zero.
- R3: Bit 0 of breakpoint 0 always reads back as 0, whatever was written to it.
- R4: Breakpoint 0 matches when the PC equals it on every bit from 1 upward whose mask bit is clear. Address bits whose mask bit is set are ignored in the comparison.
- R5: Breakpoints 1 to 3 match when their bit 0 (valid) is 1 and the PC equals them on all bits from 1 upward. No masking applies to them.
- R6: A breakpoint among 1 to 3 whose valid bit is 0 never contributes a match.
- R7: While the enable bit is 0, `pc_trig` stays low for every PC.
- R8: With the invert bit 0, the trigger fires for a PC inside the region, which is the OR of all matches. With the invert bit 1, it fires for a PC outside the region.
- R9: A PC is evaluated only when `pc_valid` is high. For each qualifying PC, `pc_trig` is high for exactly the cycle after the PC was sampled, and it is low after a cycle with `pc_valid` low.
- R10: PC bit 0 never affects the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (width follows breakpoint count) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Registered read data for the previous cycle's select |
| pc_valid | input | 1 | PC sample strobe |
| pc | input | ADDR_W | Program counter value |
| pc_trig | output | 1 | One-cycle PC trigger pulse |

## Verification
A register write takes effect at the clock edge where `reg_we` is high. Read data for a select appears one edge after the select is presented. The trigger for a PC appears one edge after the PC is sampled. The bench drives inputs on falling edges and samples outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Each PC sweep covers every address of a narrow 6-bit configuration and is compared with a region model computed arithmetically from the values written. A cycle with the strobe dropped is then checked to confirm that the pulse does not stretch.

// File: rtl/pcbk_pkg.sv
package pcbk_pkg;
  // control word bit positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INV_BIT = 1;
  // breakpoint valid flag / ignored address bit
  localparam int VALID_BIT    = 0;

  function automatic int reg_aw(input int nbkpt);
    return $clog2(nbkpt + 2);
  endfunction
endpackage

// File: rtl/pcbk_regs.sv
module pcbk_regs
  import pcbk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4,
  localparam int REG_AW  = reg_aw(NUM_BKPT)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [REG_AW-1:0]                addr,
  input  logic [ADDR_W-1:0]                wdata,
  output logic [ADDR_W-1:0]                rdata,
  output logic [NUM_BKPT-1:0][ADDR_W-1:0]  bkpt,
  output logic [ADDR_W-1:0]                mask,
  output logic                             ctrl_en,
  output logic                             ctrl_inv
);
  localparam int MASK_SEL = NUM_BKPT;
  localparam int CTRL_SEL = NUM_BKPT + 1;

  logic [NUM_BKPT-1:0][ADDR_W-1:0] bkpt_q;
  logic [ADDR_W-1:0]               mask_q;
  logic                            en_q, inv_q;
  logic [ADDR_W-1:0]               rd_mux, rdata_q;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_bk
    always_ff @(posedge clk) begin
      if (rst)
        bkpt_q[g] <= '0;
      else if (we && addr == REG_AW'(g)) begin
        if (g == 0)
          bkpt_q[g] <= {wdata[ADDR_W-1:1], 1'b0};
        else
          bkpt_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      inv_q  <= 1'b0;
    end else if (we) begin
      if (addr == REG_AW'(MASK_SEL))
        mask_q <= wdata;
      if (addr == REG_AW'(CTRL_SEL)) begin
        en_q  <= wdata[CTRL_EN_BIT];
        inv_q <= wdata[CTRL_INV_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BKPT; i++)
      if (addr == REG_AW'(i)) rd_mux = bkpt_q[i];
    if (addr == REG_AW'(MASK_SEL)) rd_mux = mask_q;
    if (addr == REG_AW'(CTRL_SEL)) begin
      rd_mux[CTRL_EN_BIT]  = en_q;
      rd_mux[CTRL_INV_BIT] = inv_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign bkpt     = bkpt_q;
  assign mask     = mask_q;
  assign ctrl_en  = en_q;
  assign ctrl_inv = inv_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '0 && !en_q && !inv_q && rdata_q == '0));

  // R3
  bk0_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == '0) |-> (rdata_q[VALID_BIT] == 1'b0));
endmodule

// File: rtl/pcbk_match.sv
module pcbk_match
  import pcbk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4
) (
  input  logic [ADDR_W-1:0]               pc,
  input  logic [NUM_BKPT-1:0][ADDR_W-1:0] bkpt,
  input  logic [ADDR_W-1:0]               mask,
  output logic                            in_region
);
  localparam logic [ADDR_W-1:0] LSB_OFF = ~(ADDR_W'(1));

  logic [NUM_BKPT-1:0] hit;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_cmp
    if (g == 0) begin : g_masked
      assign hit[g] = (((pc ^ bkpt[g]) & ~mask & LSB_OFF) == '0);
    end else begin : g_exact
      assign hit[g] = bkpt[g][VALID_BIT] &&
                      (((pc ^ bkpt[g]) & LSB_OFF) == '0);
    end
  end

  assign in_region = |hit;
endmodule

// File: rtl/pc_bkpt_trigger.sv
module pc_bkpt_trigger
  import pcbk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4,
  localparam int REG_AW  = reg_aw(NUM_BKPT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  output logic              pc_trig
);
  logic [NUM_BKPT-1:0][ADDR_W-1:0] bkpt;
  logic [ADDR_W-1:0]               mask;
  logic                            ctrl_en, ctrl_inv, in_region;
  logic                            trig_q;

  pcbk_regs #(.ADDR_W(ADDR_W), .NUM_BKPT(NUM_BKPT)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .bkpt(bkpt), .mask(mask),
    .ctrl_en(ctrl_en), .ctrl_inv(ctrl_inv)
  );

  pcbk_match #(.ADDR_W(ADDR_W), .NUM_BKPT(NUM_BKPT)) u_match (
    .pc(pc), .bkpt(bkpt), .mask(mask), .in_region(in_region)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= pc_valid && ctrl_en && (in_region ^ ctrl_inv);
  end

  assign pc_trig = trig_q;

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !pc_trig);

  // R9
  valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_valid |=> !pc_trig);

  // R8
  invert_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_valid && ctrl_en && ctrl_inv && in_region) |=> !pc_trig);

  // R8
  direct_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_valid && ctrl_en && !ctrl_inv && in_region) |=> pc_trig);
endmodule

// File: tb/pc_bkpt_trigger_bench.sv
module pc_bkpt_trigger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 0, rst = 1, reg_we = 0, pc_valid = 0;
  logic [2:0]    reg_addr = 0;
  logic [AW-1:0] reg_wdata = 0, pc = 0;
  logic [AW-1:0] reg_rdata;
  logic          pc_trig;

  int checks = 0, errors = 0;

  logic [AW-1:0] m_bk [4];
  logic [AW-1:0] m_mask;
  logic          m_en, m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_bkpt_trigger #(.ADDR_W(AW), .NUM_BKPT(4)) u_pc_bkpt_trigger (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc_valid(pc_valid),
    .pc(pc), .pc_trig(pc_trig)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [AW-1:0] d);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a < 4) m_bk[a] = (a == 0) ? {d[AW-1:1], 1'b0} : d;
    else if (a == 4) m_mask = d;
    else if (a == 5) begin m_en = d[0]; m_inv = d[1]; end
  endtask

  task automatic rd(string req, int a, logic [AW-1:0] exp);
    reg_addr = 3'(a);
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  function automatic logic region(logic [AW-1:0] p);
    logic h;
    h = (((p ^ m_bk[0]) & ~m_mask & 6'h3E) == 0);
    for (int i = 1; i < 4; i++)
      if (m_bk[i][0] && (((p ^ m_bk[i]) & 6'h3E) == 0)) h = 1;
    return h;
  endfunction

  task automatic sweep(string req, logic pv);
    for (int p = 0; p < 64; p++) begin
      pc = AW'(p); pc_valid = pv;
      @(negedge clk);
      check(req, AW'(pc_trig), AW'(pv & m_en & (region(AW'(p)) ^ m_inv)));
    end
    pc_valid = 0;
    @(negedge clk);
    check("R9 pulse ends", AW'(pc_trig), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_bk[i] = 0;
    m_mask = 0; m_en = 0; m_inv = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 trig", AW'(pc_trig), 0);
    for (int a = 0; a < 6; a++) rd("R1 reset value", a, 0);

    // R7: disabled, reset region would cover PC 0/1
    sweep("R7 disabled", 1);

    // R2/R3 register access
    wr(0, 6'h15); rd("R3 bk0 lsb", 0, 6'h14);
    wr(1, 6'h31); rd("R2 bk1", 1, 6'h31);
    wr(2, 6'h08); rd("R2 bk2", 2, 6'h08);
    wr(3, 6'h2B); rd("R2 bk3", 3, 6'h2B);
    wr(4, 6'h03); rd("R2 mask", 4, 6'h03);
    wr(5, 6'h3D); rd("R2 ctrl", 5, 6'h01);
    rd("R2 unmapped", 6, 0);
    rd("R2 unmapped", 7, 0);

    // R4/R5/R6/R10: masked region 20..23 plus 0x30/31 and 0x2A/2B; bk2 invalid
    sweep("R4 R5 R6 R10 inside", 1);
    sweep("R9 no strobe", 0);

    wr(4, 6'h0C); wr(3, 6'h2A);
    sweep("R4 wider mask R6 bk3 off", 1);

    wr(5, 6'h03);
    sweep("R8 invert", 1);

    wr(2, 6'h09); wr(4, 6'h00);
    sweep("R8 invert R5 bk2", 1);

    wr(5, 6'h02);
    sweep("R7 disabled invert", 1);

    wr(5, 6'h01);
    sweep("R5 exact after changes", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule